// File: doc/BRIEF.md
# Self-Triggered Event Slot Controller

This block runs the digital side of a self-triggered readout during a bunch train. A free-running crossing counter steps once for each crossing strobe and wraps after 255. Each of the 36 channel discriminators drives one trigger bit, and the block treats the OR of these bits as the event trigger. When the block is armed, a trigger records an event in the next free slot. The block sends a one-cycle hold pulse and the slot index to the analog sample-and-hold. In the same step it stores which channels fired and the crossing number of that cycle, then advances its slot pointer.

After each event the block is blind until the next crossing strobe re-arms it. Sixteen slots are available. After the last one is filled, a full flag rises and all further triggers are ignored until reset. Stored records are read through a plain random-access port. No valid/ready stream is used here, because a trigger from the detector cannot be held back, and reads have no side effects, so back-pressure has nothing to act on.

Top module: `evt_slot_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released: `hold_pulse`=0, `bx_count`=0, `used_slots`=0, `full`=0, `armed`=1, `rd_valid`=0 and `rd_hits`/`rd_stamp` read zero for every slot.
- R2: `bx_count` rises by one in the cycle after each cycle with `bx_tick`=1, wraps from 255 to 0, and otherwise keeps its value.
- R3: A cycle with `armed`=1 and any bit of `chan_trig` at 1 is a capture. The next cycle shows `hold_pulse`=1 for exactly one cycle, with `hold_slot` giving the slot written. Slots fill in the order 0, 1, 2 … 15.
- R4: A captured slot's hit map equals the `chan_trig` vector of the capture cycle, with bit i standing for channel i. The map appears on `rd_hits` when `rd_slot` selects that slot.
- R5: A captured slot's stamp equals the `bx_count` value seen in the capture cycle, even when `bx_tick` is also 1 in that cycle. The stamp appears on `rd_stamp`.
- R6: After a capture, `armed` is 0 and triggers are ignored: no hold pulse and no change to any slot. This lasts until a cycle with `bx_tick`=1 that follows the capture cycle. `armed` returns to 1 in the cycle after that tick. A tick in the capture cycle itself does not re-arm the block.
- R7: `used_slots` counts the captures since reset. `full` rises with the 16th capture, in the same cycle in which `used_slots` reaches 16.
- R8: While `full`=1, `armed` reads 0 and triggers cause no hold pulse and no change to any stored record, until reset.
- R9: `rd_valid` is 1 exactly when `rd_slot` is below `used_slots`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bx_tick | input | 1 | One-cycle strobe marking a crossing boundary |
| chan_trig | input | 36 | Per-channel discriminator outputs, bit i = channel i |
| rd_slot | input | 4 | Slot selected on the read port |
| hold_pulse | output | 1 | One-cycle hold command for the analog sample-and-hold |
| hold_slot | output | 4 | Slot index that goes with the hold command |
| bx_count | output | 8 | Current crossing number |
| armed | output | 1 | Block will accept a trigger in this cycle |
| full | output | 1 | All slots are used |
| used_slots | output | 5 | Number of slots filled since reset |
| rd_hits | output | 36 | Hit map of the selected slot |
| rd_stamp | output | 8 | Crossing stamp of the selected slot |
| rd_valid | output | 1 | Selected slot holds a record |

## Verification
A slot pointer that skips or repeats shows up on `hold_slot` at the very next hold pulse. It also shows up on the read port as soon as that slot is selected, as a lost or overwritten record. A stuck or early re-arm shows as a hold pulse in the cycle after a trigger that arrives before the next tick. A stamp or counter that is off by one becomes visible on `rd_stamp` one cycle after the capture. A wrong fill count shows on `used_slots`, `full` and `rd_valid` in the cycle after the capture that exposes it. The bench compares every output in every cycle against a cycle model, and it reads a randomly chosen slot each cycle, so any of these faults is reported within one cycle of first reaching the ports.

// File: rtl/evt_slot_pkg.sv
package evt_slot_pkg;
  // Default geometry of the controller
  localparam int unsigned DEF_N_CH  = 36;
  localparam int unsigned DEF_DEPTH = 16;
  localparam int unsigned DEF_BX_W  = 8;

  // Trigger arming state: waiting for a crossing boundary, or ready to capture
  typedef enum logic {
    ARM_WAIT  = 1'b0,
    ARM_READY = 1'b1
  } arm_state_e;
endpackage

// File: rtl/evt_bx_counter.sv
module evt_bx_counter #(
  parameter int unsigned BX_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bx_tick,
  output logic [BX_W-1:0] bx_count
);
  logic [BX_W-1:0] cnt_q;

  // Natural binary wrap at the all-ones value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (bx_tick) cnt_q <= cnt_q + BX_W'(1);
  end

  assign bx_count = cnt_q;
endmodule

// File: rtl/evt_rearm.sv
module evt_rearm
  import evt_slot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bx_tick,
  input  logic any_hit,
  input  logic full,
  output logic capture,
  output logic armed
);
  arm_state_e st_q, st_d;

  // An event is taken only when ready and a free slot exists
  assign capture = (st_q == ARM_READY) && !full && any_hit;

  // A capture always disarms, even when a tick arrives in the same cycle
  always_comb begin
    st_d = st_q;
    if (capture)                            st_d = ARM_WAIT;
    else if (st_q == ARM_WAIT && bx_tick)   st_d = ARM_READY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ARM_READY;
    else        st_q <= st_d;
  end

  assign armed = (st_q == ARM_READY) && !full;
endmodule

// File: rtl/evt_slot_ptr.sv
module evt_slot_ptr #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  output logic [PTR_W-1:0] wr_idx,
  output logic [CNT_W-1:0] used_slots,
  output logic             full,
  output logic             hold_pulse,
  output logic [PTR_W-1:0] hold_slot
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] used_q;
  logic             hold_q;
  logic [PTR_W-1:0] hslot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      used_q <= '0;
    end else if (capture) begin
      ptr_q  <= (ptr_q == LAST_IDX) ? '0 : ptr_q + PTR_W'(1);
      used_q <= used_q + CNT_W'(1);
    end
  end

  // Hold command registered so it lines up with the stored record
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      hslot_q <= '0;
    end else begin
      hold_q <= capture;
      if (capture) hslot_q <= ptr_q;
    end
  end

  assign wr_idx     = ptr_q;
  assign used_slots = used_q;
  assign full       = (used_q == CNT_MAX);
  assign hold_pulse = hold_q;
  assign hold_slot  = hslot_q;
endmodule

// File: rtl/evt_slot_store.sv
module evt_slot_store #(
  parameter int unsigned N_CH  = 36,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned BX_W  = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic [N_CH-1:0]  wr_hits,
  input  logic [BX_W-1:0]  wr_stamp,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [N_CH-1:0]  rd_hits,
  output logic [BX_W-1:0]  rd_stamp
);
  logic [N_CH-1:0] hit_mem   [DEPTH];
  logic [BX_W-1:0] stamp_mem [DEPTH];

  // One register row per slot, each with its own decoded write enable
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic sel;
    assign sel = we && (wr_idx == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit_mem[g]   <= '0;
        stamp_mem[g] <= '0;
      end else if (sel) begin
        hit_mem[g]   <= wr_hits;
        stamp_mem[g] <= wr_stamp;
      end
    end
  end

  // Read mux; indices beyond the depth read zero
  always_comb begin
    rd_hits  = '0;
    rd_stamp = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == PTR_W'(i)) begin
        rd_hits  = hit_mem[i];
        rd_stamp = stamp_mem[i];
      end
    end
  end
endmodule

// File: rtl/evt_slot_ctrl.sv
module evt_slot_ctrl #(
  parameter int unsigned N_CH  = evt_slot_pkg::DEF_N_CH,
  parameter int unsigned DEPTH = evt_slot_pkg::DEF_DEPTH,
  parameter int unsigned BX_W  = evt_slot_pkg::DEF_BX_W,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bx_tick,
  input  logic [N_CH-1:0]  chan_trig,
  input  logic [PTR_W-1:0] rd_slot,
  output logic             hold_pulse,
  output logic [PTR_W-1:0] hold_slot,
  output logic [BX_W-1:0]  bx_count,
  output logic             armed,
  output logic             full,
  output logic [CNT_W-1:0] used_slots,
  output logic [N_CH-1:0]  rd_hits,
  output logic [BX_W-1:0]  rd_stamp,
  output logic             rd_valid
);
  logic             any_hit;
  logic             capture;
  logic [PTR_W-1:0] wr_idx;

  // Event trigger: OR over all channel discriminators
  assign any_hit = |chan_trig;

  evt_bx_counter #(.BX_W(BX_W)) u_bx (
    .clk      (clk),
    .rst_n    (rst_n),
    .bx_tick  (bx_tick),
    .bx_count (bx_count)
  );

  evt_rearm u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .bx_tick (bx_tick),
    .any_hit (any_hit),
    .full    (full),
    .capture (capture),
    .armed   (armed)
  );

  evt_slot_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (capture),
    .wr_idx     (wr_idx),
    .used_slots (used_slots),
    .full       (full),
    .hold_pulse (hold_pulse),
    .hold_slot  (hold_slot)
  );

  // Stamp taken from the counter value before any same-cycle tick
  evt_slot_store #(.N_CH(N_CH), .DEPTH(DEPTH), .BX_W(BX_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (capture),
    .wr_idx   (wr_idx),
    .wr_hits  (chan_trig),
    .wr_stamp (bx_count),
    .rd_idx   (rd_slot),
    .rd_hits  (rd_hits),
    .rd_stamp (rd_stamp)
  );

  assign rd_valid = {1'b0, rd_slot} < used_slots;
endmodule

// File: rtl/evt_slot_ctrl_chk.sv
module evt_slot_ctrl_chk #(
  parameter int unsigned N_CH  = 36,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned BX_W  = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bx_tick,
  input logic [N_CH-1:0]  chan_trig,
  input logic [PTR_W-1:0] rd_slot,
  input logic             hold_pulse,
  input logic [PTR_W-1:0] hold_slot,
  input logic [BX_W-1:0]  bx_count,
  input logic             armed,
  input logic             full,
  input logic [CNT_W-1:0] used_slots,
  input logic [N_CH-1:0]  rd_hits,
  input logic [BX_W-1:0]  rd_stamp
);
  p_bx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bx_tick |=> bx_count == $past(bx_count) + BX_W'(1));

  p_bx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bx_tick |=> $stable(bx_count));

  p_hold_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_pulse |-> $past(armed) && $past(|chan_trig));

  p_hits_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_pulse && rd_slot == hold_slot) |-> rd_hits == $past(chan_trig));

  p_stamp_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_pulse && rd_slot == hold_slot) |-> rd_stamp == $past(bx_count));

  p_single_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_pulse |=> !hold_pulse);

  p_rearm_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(bx_tick));

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_pulse |-> used_slots == $past(used_slots) + CNT_W'(1));

  p_full_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full && !hold_pulse && !armed);
endmodule

bind evt_slot_ctrl evt_slot_ctrl_chk #(.N_CH(N_CH), .DEPTH(DEPTH), .BX_W(BX_W)) u_chk (.*);

// File: tb/evt_slot_ctrl_bench.sv
module evt_slot_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH  = 36;
  localparam int DEPTH = 16;
  localparam int BX_W  = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bx_tick = 1'b0;
  logic [N_CH-1:0] chan_trig = '0;
  logic [3:0]      rd_slot = '0;
  logic            hold_pulse;
  logic [3:0]      hold_slot;
  logic [BX_W-1:0] bx_count;
  logic            armed, full, rd_valid;
  logic [4:0]      used_slots;
  logic [N_CH-1:0] rd_hits;
  logic [BX_W-1:0] rd_stamp;

  evt_slot_ctrl u_evt_slot_ctrl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;

  // Reference model state
  logic            m_arm;
  int              m_used;
  logic [BX_W-1:0] m_bx;
  logic            m_hold;
  logic [3:0]      m_hslot;
  logic [N_CH-1:0] m_hit   [DEPTH];
  logic [BX_W-1:0] m_stamp [DEPTH];

  function automatic logic f_full(int used);
    return used >= DEPTH;
  endfunction

  function automatic logic f_armed(logic arm, int used);
    return arm && !f_full(used);
  endfunction

  function automatic logic [BX_W-1:0] f_next_bx(logic [BX_W-1:0] bx, logic t);
    return t ? bx + BX_W'(1) : bx;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_arm = 1'b1; m_used = 0; m_bx = '0; m_hold = 1'b0; m_hslot = '0;
    for (int i = 0; i < DEPTH; i++) begin m_hit[i] = '0; m_stamp[i] = '0; end
  endtask

  task automatic compare_all();
    string rq;
    rq = f_full(m_used) ? "R8" : "R3";
    chk(rq, "hold_pulse", 64'(hold_pulse), 64'(m_hold));
    if (m_hold) chk("R3", "hold_slot", 64'(hold_slot), 64'(m_hslot));
    chk("R2", "bx_count", 64'(bx_count), 64'(m_bx));
    chk(f_full(m_used) ? "R8" : "R6", "armed", 64'(armed), 64'(f_armed(m_arm, m_used)));
    chk("R7", "full", 64'(full), 64'(f_full(m_used)));
    chk("R7", "used_slots", 64'(used_slots), 64'(m_used));
    chk("R9", "rd_valid", 64'(rd_valid), 64'(int'(rd_slot) < m_used));
    chk("R4", "rd_hits", 64'(rd_hits), 64'(m_hit[rd_slot]));
    chk("R5", "rd_stamp", 64'(rd_stamp), 64'(m_stamp[rd_slot]));
  endtask

  task automatic step(logic t, logic [N_CH-1:0] tr, logic [3:0] rs);
    logic cap;
    @(negedge clk);
    bx_tick = t; chan_trig = tr; rd_slot = rs;
    @(posedge clk);
    cap = f_armed(m_arm, m_used) && (|tr);
    m_hold = cap;
    if (cap) begin
      m_hslot = 4'(m_used);
      m_hit[m_used % DEPTH]   = tr;
      m_stamp[m_used % DEPTH] = m_bx;
      m_used++;
      m_arm = 1'b0;
    end else if (t) begin
      m_arm = 1'b1;
    end
    m_bx = f_next_bx(m_bx, t);
    #1;
    compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bx_tick = 1'b0; chan_trig = '0;
    model_reset();
    repeat (2) @(negedge clk);
    chk("R1", "hold_pulse in reset", 64'(hold_pulse), 64'(0));
    rst_n = 1'b1;
    #1;
    chk("R1", "bx_count", 64'(bx_count), 64'(0));
    chk("R1", "used_slots", 64'(used_slots), 64'(0));
    chk("R1", "full", 64'(full), 64'(0));
    chk("R1", "armed", 64'(armed), 64'(1));
    chk("R1", "rd_valid", 64'(rd_valid), 64'(0));
    chk("R1", "rd_hits", 64'(rd_hits), 64'(0));
    chk("R1", "rd_stamp", 64'(rd_stamp), 64'(0));
  endtask

  function automatic logic [N_CH-1:0] rand_pattern();
    logic [63:0] r;
    int k;
    k = $urandom_range(0, 5);
    r = {$urandom(), $urandom()};
    case (k)
      0: return '0;
      1: return N_CH'(1) << $urandom_range(0, N_CH - 1);
      2: return '1;
      default: return r[N_CH-1:0];
    endcase
  endfunction

  // Watchdog: an expired run counts as a failure
  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    do_reset();

    // R3/R4/R5: first capture into slot 0
    step(1'b0, 36'h0_0000_0A5C, 4'd0);
    // R6: disarmed, trigger ignored
    step(1'b0, 36'hF_0000_0001, 4'd1);
    // R6: trigger with tick while disarmed: ignored, re-arms
    step(1'b1, 36'h8_0000_0000, 4'd1);
    // R5/R6: capture with tick in same cycle, stamp pre-increment, no re-arm
    step(1'b1, 36'h8_0000_0000, 4'd1);
    step(1'b0, 36'h0_0000_0001, 4'd1);
    chk("R6", "slot 2 untouched after blocked trigger", 64'(used_slots), 64'(2));
    // channel 0 only
    step(1'b1, '0, 4'd2);
    step(1'b0, 36'h0_0000_0001, 4'd2);

    // R7/R8: fill remaining slots
    while (m_used < DEPTH) begin
      step(1'b1, '0, 4'(m_used));
      step(1'b0, rand_pattern() | 36'h1_0000_0000, 4'(m_used - 1));
    end
    chk("R7", "full after 16", 64'(full), 64'(1));
    for (int i = 0; i < 20; i++) step(i[0], '1, 4'(i));
    for (int i = 0; i < DEPTH; i++) step(1'b0, '0, 4'(i));

    // R2: long tick run through the wrap
    for (int i = 0; i < 300; i++) step(1'b1, '0, 4'(i));
    chk("R2", "bx after 300 extra ticks", 64'(bx_count), 64'(m_bx));

    // Random mixture with occasional reset
    do_reset();
    for (int i = 0; i < 8000; i++) begin
      if (f_full(m_used) && $urandom_range(0, 30) == 0) do_reset();
      step($urandom_range(0, 3) == 0, ($urandom_range(0, 2) == 0) ? rand_pattern() : '0,
           4'($urandom_range(0, DEPTH - 1)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule